// File: doc/BRIEF.md
# Sixteen-bit integer execute unit

This block is the integer execute stage of a 16-bit general-register processor. It is purely combinational. An operation code, two source operands, the current value of the destination register and an 8-bit immediate go in. One 16-bit result comes out in the same cycle, together with a flag that tells the register file whether to write it.

The operation set covers:
- modular addition;
- the three bitwise combiners (AND, XOR, OR);
- two's-complement negation;
- a logical not that yields exactly 0 or 1;
- an arithmetic right shift by a register amount;
- loading a sign-extended immediate;
- shift-in-immediate, which lets software build a 16-bit constant eight bits at a time.

Codes outside the defined set produce a zero result and suppress the register write. Instruction decode, the register file, memory access and logarithmic-number arithmetic sit outside this block.

Top module: `int_exec_unit`

## Requirements
- R1: Code 0 (add) gives src_s + src_t modulo 2^16; a carry out of bit 15 is dropped and no flag reports it.
- R2: Code 1 gives src_s AND src_t, code 2 gives src_s XOR src_t, code 3 gives src_s OR src_t, all bit by bit.
- R3: Code 4 (minus) gives the two's-complement negation of src_s, so 0x8000 maps to itself and 0 maps to 0.
- R4: Code 5 (logical not) gives 0x0001 when src_s is zero and 0x0000 for any other src_s.
- R5: Code 6 shifts src_s right arithmetically by the unsigned amount in src_t; any amount of 15 or more gives sixteen copies of the sign bit of src_s.
- R6: Code 7 (load immediate) gives imm8 sign-extended from bit 7 to 16 bits.
- R7: Code 8 (shift-in) gives dst_old shifted left by 8, with imm8 zero-extended in bits 7..0; the upper byte of dst_old is discarded.
- R8: reg_wr is 1 for every code from 0 through 8.
- R9: For codes 9 through 15, result is 0x0000 and reg_wr is 0, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (0 add, 1 and, 2 xor, 3 or, 4 minus, 5 logical not, 6 arithmetic shift right, 7 load immediate, 8 shift-in) |
| src_s | input | 16 | First source operand |
| src_t | input | 16 | Second source operand; the shift amount for code 6 |
| dst_old | input | 16 | Current destination register value, used by shift-in |
| imm8 | input | 8 | Immediate field |
| result | output | 16 | Operation result |
| reg_wr | output | 1 | Register-write indication |

## Verification
The assertions sample the block combinationally and take every input as a known two-state value. They also assume op_sel is held steady long enough for the result to settle; they make no assumption about which codes arrive. The stimulus changes all inputs together once per clock, only after the rising edge, and leaves them fixed until the comparison at the following falling edge. The codes and operands it applies include the unused codes 9 to 15, shift amounts far above 15, and the boundary operands 0x0000, 0x7FFF, 0x8000 and 0xFFFF.

// File: rtl/iex_pkg.sv
package iex_pkg;
  localparam int DATA_W = 16;
  localparam int IMM_W  = 8;
  localparam int OP_W   = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_AND  = 4'd1,
    OP_XOR  = 4'd2,
    OP_OR   = 4'd3,
    OP_NEG  = 4'd4,
    OP_LNOT = 4'd5,
    OP_ASR  = 4'd6,
    OP_LDI  = 4'd7,
    OP_SHI  = 4'd8
  } iex_op_e;
endpackage

// File: rtl/iex_arith.sv
module iex_arith #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] src_s,
  input  logic [DATA_W-1:0] src_t,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W-1:0] neg_o,
  output logic [DATA_W-1:0] lnot_o
);
  // modular sum, carry discarded
  assign sum_o  = src_s + src_t;
  assign neg_o  = (~src_s) + {{(DATA_W-1){1'b0}}, 1'b1};
  assign lnot_o = {{(DATA_W-1){1'b0}}, ~(|src_s)};
endmodule

// File: rtl/iex_logic.sv
module iex_logic #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] src_s,
  input  logic [DATA_W-1:0] src_t,
  output logic [DATA_W-1:0] and_o,
  output logic [DATA_W-1:0] xor_o,
  output logic [DATA_W-1:0] or_o
);
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign and_o[b] = src_s[b] & src_t[b];
    assign xor_o[b] = src_s[b] ^ src_t[b];
    assign or_o[b]  = src_s[b] | src_t[b];
  end
endmodule

// File: rtl/iex_shift.sv
module iex_shift #(
  parameter int DATA_W = 16,
  parameter int IMM_W  = 8
) (
  input  logic [DATA_W-1:0] src_s,
  input  logic [DATA_W-1:0] src_t,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [IMM_W-1:0]  imm8,
  output logic [DATA_W-1:0] asr_o,
  output logic [DATA_W-1:0] ldi_o,
  output logic [DATA_W-1:0] shi_o
);
  localparam int AMT_W = $clog2(DATA_W);
  localparam logic [AMT_W-1:0] AMT_MAX = AMT_W'(DATA_W-1);

  logic             amt_big;
  logic [AMT_W-1:0] amt;

  // any bit above the amount field saturates to a full sign fill
  assign amt_big = |src_t[DATA_W-1:AMT_W];
  assign amt     = amt_big ? AMT_MAX : src_t[AMT_W-1:0];
  assign asr_o   = DATA_W'($signed(src_s) >>> amt);

  assign ldi_o = {{(DATA_W-IMM_W){imm8[IMM_W-1]}}, imm8};
  assign shi_o = {dst_old[DATA_W-IMM_W-1:0], imm8};
endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
  import iex_pkg::*;
(
  input  logic [OP_W-1:0]   op_sel,
  input  logic [DATA_W-1:0] src_s,
  input  logic [DATA_W-1:0] src_t,
  input  logic [DATA_W-1:0] dst_old,
  input  logic [IMM_W-1:0]  imm8,
  output logic [DATA_W-1:0] result,
  output logic              reg_wr
);
  logic [DATA_W-1:0] sum_w, neg_w, lnot_w;
  logic [DATA_W-1:0] and_w, xor_w, or_w;
  logic [DATA_W-1:0] asr_w, ldi_w, shi_w;

  iex_arith #(.DATA_W(DATA_W)) u_arith (
    .src_s  (src_s),
    .src_t  (src_t),
    .sum_o  (sum_w),
    .neg_o  (neg_w),
    .lnot_o (lnot_w)
  );

  iex_logic #(.DATA_W(DATA_W)) u_logic (
    .src_s (src_s),
    .src_t (src_t),
    .and_o (and_w),
    .xor_o (xor_w),
    .or_o  (or_w)
  );

  iex_shift #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_shift (
    .src_s   (src_s),
    .src_t   (src_t),
    .dst_old (dst_old),
    .imm8    (imm8),
    .asr_o   (asr_w),
    .ldi_o   (ldi_w),
    .shi_o   (shi_w)
  );

  always_comb begin
    result = '0;
    reg_wr = 1'b1;
    case (op_sel)
      OP_ADD:  result = sum_w;
      OP_AND:  result = and_w;
      OP_XOR:  result = xor_w;
      OP_OR:   result = or_w;
      OP_NEG:  result = neg_w;
      OP_LNOT: result = lnot_w;
      OP_ASR:  result = asr_w;
      OP_LDI:  result = ldi_w;
      OP_SHI:  result = shi_w;
      default: reg_wr = 1'b0;
    endcase
  end
endmodule

// File: rtl/int_exec_unit_checker.sv
module int_exec_unit_checker
  import iex_pkg::*;
(
  input logic [OP_W-1:0]   op_sel,
  input logic [DATA_W-1:0] src_s,
  input logic [DATA_W-1:0] src_t,
  input logic [DATA_W-1:0] dst_old,
  input logic [IMM_W-1:0]  imm8,
  input logic [DATA_W-1:0] result,
  input logic              reg_wr
);
  always_comb begin
    if (op_sel == OP_ADD)
      assert_add_inverse_R1: assert (DATA_W'(result - src_t) == src_s)
        else $error("add result does not invert");
    if (op_sel == OP_NEG)
      assert_neg_sum_zero_R3: assert (DATA_W'(result + src_s) == '0)
        else $error("negation plus operand not zero");
    if (op_sel == OP_LNOT)
      assert_lnot_bool_R4: assert ((result[DATA_W-1:1] == '0) && (result[0] == (src_s == '0)))
        else $error("logical not out of range");
    if (op_sel == OP_ASR)
      assert_asr_sign_R5: assert (result[DATA_W-1] == src_s[DATA_W-1])
        else $error("shift lost sign");
    if (op_sel == OP_LDI)
      assert_ldi_ext_R6: assert ((result[IMM_W-1:0] == imm8) &&
                                 ($countones(result[DATA_W-1:IMM_W-1]) == (imm8[IMM_W-1] ? DATA_W-IMM_W+1 : 0)))
        else $error("immediate not sign extended");
    if (op_sel == OP_SHI)
      assert_shi_bytes_R7: assert ((result[IMM_W-1:0] == imm8) &&
                                   (result[DATA_W-1:IMM_W] == dst_old[DATA_W-IMM_W-1:0]))
        else $error("shift-in bytes misplaced");
    if (op_sel <= OP_SHI)
      assert_wr_valid_R8: assert (reg_wr)
        else $error("write dropped on valid code");
    else
      assert_idle_invalid_R9: assert (!reg_wr && result == '0)
        else $error("invalid code produced output");
  end
endmodule

bind int_exec_unit int_exec_unit_checker u_chk (
  .op_sel  (op_sel),
  .src_s   (src_s),
  .src_t   (src_t),
  .dst_old (dst_old),
  .imm8    (imm8),
  .result  (result),
  .reg_wr  (reg_wr)
);

// File: tb/int_exec_unit_bench.sv
module int_exec_unit_bench;
  logic        clk;
  logic        rst_n;
  logic [3:0]  op_sel;
  logic [15:0] src_s, src_t, dst_old;
  logic [7:0]  imm8;
  logic [15:0] result;
  logic        reg_wr;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done   = 0;

  typedef struct {
    logic [15:0] res;
    logic        wr;
    string       req;
  } exp_t;
  exp_t sb_q[$];

  int_exec_unit u_int_exec_unit (
    .op_sel (op_sel), .src_s (src_s), .src_t (src_t), .dst_old (dst_old),
    .imm8 (imm8), .result (result), .reg_wr (reg_wr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // reference model written from the requirements
  function automatic logic [15:0] ref_res(input logic [3:0] op, input logic [15:0] s,
                                          input logic [15:0] t, input logic [15:0] d,
                                          input logic [7:0] i);
    logic [15:0] v;
    case (op)
      4'd0: return 16'((32'(s) + 32'(t)) % 32'h10000);
      4'd1: return s & t;
      4'd2: return s ^ t;
      4'd3: return s | t;
      4'd4: return 16'(32'h10000 - 32'(s));
      4'd5: return (s == 16'd0) ? 16'd1 : 16'd0;
      4'd6: begin
        v = s;
        for (int k = 0; k < 16 && k < int'(t); k++) v = {s[15], v[15:1]};
        return v;
      end
      4'd7: return {{8{i[7]}}, i};
      4'd8: return 16'(32'(d) * 256 + 32'(i));
      default: return 16'd0;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1, 4'd2, 4'd3: return "R2";
      4'd4: return "R3";
      4'd5: return "R4";
      4'd6: return "R5";
      4'd7: return "R6";
      4'd8: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic drive(input logic [3:0] op, input logic [15:0] s, input logic [15:0] t,
                       input logic [15:0] d, input logic [7:0] i);
    exp_t e;
    @(posedge clk);
    #1;
    op_sel = op; src_s = s; src_t = t; dst_old = d; imm8 = i;
    e.res = ref_res(op, s, t, d, i);
    e.wr  = (op <= 4'd8);
    e.req = req_of(op);
    sb_q.push_back(e);
  endtask

  // monitor: compares at the falling edge, away from input changes
  always @(negedge clk) begin
    if (rst_n && sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if (result !== e.res) begin
        errors++;
        $display("FAIL %s result: actual %h expected %h", e.req, result, e.res);
      end
      checks++;
      if (reg_wr !== e.wr) begin
        errors++;
        $display("FAIL %s reg_wr (R8/R9): actual %b expected %b", e.req, reg_wr, e.wr);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    op_sel = 4'd15; src_s = 16'h1234; src_t = 16'h5678; dst_old = 16'h9abc; imm8 = 8'hde;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    // reset-time state: invalid code idles (R9)
    drive(4'd15, 16'hffff, 16'hffff, 16'hffff, 8'hff);
    // R1 wrap corners
    drive(4'd0, 16'h7fff, 16'h0001, 16'h0, 8'h0);
    drive(4'd0, 16'hffff, 16'h0001, 16'h0, 8'h0);
    drive(4'd0, 16'h8000, 16'h8000, 16'h0, 8'h0);
    // R2 patterns
    drive(4'd1, 16'hf0f0, 16'hff00, 16'h0, 8'h0);
    drive(4'd2, 16'hf0f0, 16'hff00, 16'h0, 8'h0);
    drive(4'd3, 16'hf0f0, 16'h0f00, 16'h0, 8'h0);
    // R3 corners
    drive(4'd4, 16'h8000, 16'h0, 16'h0, 8'h0);
    drive(4'd4, 16'h0000, 16'h0, 16'h0, 8'h0);
    drive(4'd4, 16'h0001, 16'h0, 16'h0, 8'h0);
    // R4 corners
    drive(4'd5, 16'h0000, 16'h0, 16'h0, 8'h0);
    drive(4'd5, 16'h8000, 16'h0, 16'h0, 8'h0);
    drive(4'd5, 16'h0001, 16'h0, 16'h0, 8'h0);
    // R5 amounts including saturation
    drive(4'd6, 16'h8000, 16'd0, 16'h0, 8'h0);
    drive(4'd6, 16'h8000, 16'd4, 16'h0, 8'h0);
    drive(4'd6, 16'h7fff, 16'd14, 16'h0, 8'h0);
    drive(4'd6, 16'h8001, 16'd15, 16'h0, 8'h0);
    drive(4'd6, 16'h9000, 16'd16, 16'h0, 8'h0);
    drive(4'd6, 16'h7000, 16'h0010, 16'h0, 8'h0);
    drive(4'd6, 16'hc000, 16'hffff, 16'h0, 8'h0);
    // R6
    drive(4'd7, 16'h0, 16'h0, 16'h0, 8'h80);
    drive(4'd7, 16'h0, 16'h0, 16'h0, 8'h7f);
    // R7: two steps building 0x12ab, upper byte dropped
    drive(4'd8, 16'h0, 16'h0, 16'h0012, 8'hab);
    drive(4'd8, 16'h0, 16'h0, 16'hff34, 8'h00);
    // R9 across all unused codes with busy operands
    for (int c = 9; c < 16; c++) drive(4'(c), 16'hffff, 16'h8000, 16'hffff, 8'hff);
    // random sweep over all codes (R1..R9)
    for (int n = 0; n < 3000; n++)
      drive(4'($urandom_range(0, 15)), 16'($urandom), 16'($urandom_range(0, 40)),
            16'($urandom), 8'($urandom));
    for (int n = 0; n < 500; n++)
      drive(4'd6, 16'($urandom), 16'($urandom), 16'h0, 8'h0);
    @(posedge clk);
    @(posedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule